// File: doc/BRIEF.md
# Key-Guarded Calendar Clock

This block keeps wall-clock time and a calendar date from a once-per-second tick supplied by a prescaler elsewhere on the chip. On every tick it advances seconds, minutes and hours, then day of week, day of month, month and a 12-bit year. Months are given their true lengths, and February gains a 29th day in leap years. An alarm compares any chosen subset of minute, hour, day of week and day of month against the running time. It raises a sticky flag on the tick where that subset first matches.

Software reaches the block through a simple write port. Every register except the key register is guarded. A write is accepted only after the correct 8-bit key has been written, so a runaway program cannot corrupt the time. Any wrong key closes the guard again. A ready output drops for one cycle after each tick. Software that reads the time fields while ready is high never sees a half-updated value.

Top module: `guarded_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 0, day 1, month 1, year 2000. The block is locked, ready is 1, the alarm flag is 0 and all alarm enables are off.
- R2: While locked, writes to every address other than 0 have no effect. These addresses are 1 sec, 2 min, 3 hour, 4 day of week, 5 day of month, 6 month, 7 year, 8 to 11 alarm fields, and 12 control.
- R3: A write to address 0 whose data bits [7:0] equal 0xA5 unlocks the block. A write to address 0 with any other value locks it.
- R4: Each tick advances the seconds. Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0, and each day carry moves day of week from 6 to 0.
- R5: At the end of the day, day of month wraps to 1 and the month advances. The wrap happens after day 30 in April, June, September and November, after day 28 in a common-year February, and after day 31 in the other months.
- R6: A year divisible by 4 is a leap year, except a century year not divisible by 400. February has 29 days in a leap year.
- R7: The day carry out of 31 December sets month 1 and increments the year, which wraps from 4095 to 0.
- R8: Alarm addresses 8 (minute), 9 (hour), 10 (day of week) and 11 (day of month) hold the compare value in their low bits and an enable in bit 15. The flag is set on a tick whose new time matches every enabled field when the old time did not. With no field enabled the flag is never set.
- R9: The flag stays set until an unlocked write to address 12 with bit 0 high. It is not set again while the match only persists across later ticks.
- R10: Ready is 0 in the cycle after each cycle in which tick is high, and 1 otherwise.
- R11: A tick in the same cycle as an accepted time-field write (addresses 1 to 7) is discarded. Only the written field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| sec | output | 6 | Seconds 0..59 |
| min | output | 6 | Minutes 0..59 |
| hour | output | 5 | Hours 0..23 |
| dow | output | 3 | Day of week 0..6 |
| dom | output | 5 | Day of month 1..31 |
| mon | output | 4 | Month 1..12 |
| year | output | 12 | Year |
| unlocked | output | 1 | Guard open |
| ready | output | 1 | Time fields stable for reading |
| alarm_flag | output | 1 | Sticky alarm indication |

## Verification
A faulty month-length or leap decode shows at the ports only at a month boundary, on the one tick that rolls the day. The bench therefore places the time at 23:59:59 on each critical date and checks the date right after a single tick. A guard that stays open, or a broken key compare, appears as a time field that changes after a write that should have been dropped. The bench reads that field back in the next cycle. An alarm edge that is detected wrongly shows up either as a missing flag on the matching tick or as a flag that comes back after clearing one tick later.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
    parameter int YEAR_W = 12;
    parameter int ADDR_W = 4;
    parameter int DATA_W = 16;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [3:0]        mon;
        logic [4:0]        dom;
        logic [2:0]        dow;
        logic [4:0]        hour;
        logic [5:0]        min;
        logic [5:0]        sec;
    } cal_time_t;

    typedef struct packed {
        logic       min_en;
        logic       hour_en;
        logic       dow_en;
        logic       dom_en;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
    } alarm_cfg_t;

    localparam logic [ADDR_W-1:0] A_KEY  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HOUR = 4'd3;
    localparam logic [ADDR_W-1:0] A_DOW  = 4'd4;
    localparam logic [ADDR_W-1:0] A_DOM  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
    localparam logic [ADDR_W-1:0] A_YEAR = 4'd7;
    localparam logic [ADDR_W-1:0] A_AMIN = 4'd8;
    localparam logic [ADDR_W-1:0] A_AHR  = 4'd9;
    localparam logic [ADDR_W-1:0] A_ADOW = 4'd10;
    localparam logic [ADDR_W-1:0] A_ADOM = 4'd11;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd12;
    localparam int EN_BIT = DATA_W - 1;
endpackage

// File: rtl/gcal_month_len.sv
module gcal_month_len #(
    parameter int YW = 12
) (
    input  logic [3:0]    mon,
    input  logic [YW-1:0] year,
    output logic [4:0]    days
);
    logic leap;

    always_comb begin
        leap = ((year % YW'(4)) == '0) &&
               (((year % YW'(100)) != '0) || ((year % YW'(400)) == '0));
        case (mon)
            4'd2:                    days = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: days = 5'd30;
            default:                 days = 5'd31;
        endcase
    end
endmodule

// File: rtl/gcal_advance.sv
module gcal_advance
    import gcal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic [4:0] mlen;
    logic       c_min, c_hour, c_day, c_mon, c_year;

    gcal_month_len #(.YW(YEAR_W)) u_len (
        .mon  (cur.mon),
        .year (cur.year),
        .days (mlen)
    );

    always_comb begin
        nxt    = cur;
        c_min  = cur.sec >= 6'd59;
        c_hour = c_min && (cur.min >= 6'd59);
        c_day  = c_hour && (cur.hour >= 5'd23);
        c_mon  = c_day && (cur.dom >= mlen);
        c_year = c_mon && (cur.mon >= 4'd12);

        nxt.sec = c_min ? 6'd0 : cur.sec + 6'd1;
        if (c_min)  nxt.min  = c_hour ? 6'd0 : cur.min + 6'd1;
        if (c_hour) nxt.hour = c_day ? 5'd0 : cur.hour + 5'd1;
        if (c_day) begin
            nxt.dow = (cur.dow >= 3'd6) ? 3'd0 : cur.dow + 3'd1;
            nxt.dom = c_mon ? 5'd1 : cur.dom + 5'd1;
        end
        if (c_mon)  nxt.mon  = c_year ? 4'd1 : cur.mon + 4'd1;
        if (c_year) nxt.year = cur.year + YEAR_W'(1);
    end
endmodule

// File: rtl/gcal_alarm_match.sv
module gcal_alarm_match
    import gcal_pkg::*;
(
    input  alarm_cfg_t cfg,
    input  cal_time_t  t,
    output logic       hit
);
    always_comb begin
        hit = (cfg.min_en | cfg.hour_en | cfg.dow_en | cfg.dom_en)
            && (!cfg.min_en  || (t.min  == cfg.min))
            && (!cfg.hour_en || (t.hour == cfg.hour))
            && (!cfg.dow_en  || (t.dow  == cfg.dow))
            && (!cfg.dom_en  || (t.dom  == cfg.dom));
    end
endmodule

// File: rtl/guarded_calendar.sv
module guarded_calendar
    import gcal_pkg::*;
#(
    parameter logic [7:0] KEY_VAL    = 8'hA5,
    parameter int         RESET_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [5:0]        sec,
    output logic [5:0]        min,
    output logic [4:0]        hour,
    output logic [2:0]        dow,
    output logic [4:0]        dom,
    output logic [3:0]        mon,
    output logic [YEAR_W-1:0] year,
    output logic              unlocked,
    output logic              ready,
    output logic              alarm_flag
);
    typedef struct packed {
        cal_time_t  t;
        alarm_cfg_t al;
        logic       open;
        logic       rdy;
        logic       flag;
    } state_t;

    localparam cal_time_t T_RST = '{year: YEAR_W'(RESET_YEAR), mon: 4'd1,
                                    dom: 5'd1, dow: 3'd0, hour: 5'd0,
                                    min: 6'd0, sec: 6'd0};
    localparam state_t S_RST = '{t: T_RST, al: '0, open: 1'b0,
                                 rdy: 1'b1, flag: 1'b0};

    state_t    s_d, s_q;
    cal_time_t t_adv;
    logic      hit_now, hit_adv;
    logic      acc_wr, time_wr;
    logic      unused_hi;

    assign unused_hi = ^wr_data[EN_BIT-1:YEAR_W];

    gcal_advance u_adv (
        .cur (s_q.t),
        .nxt (t_adv)
    );

    gcal_alarm_match u_hit_now (
        .cfg (s_q.al),
        .t   (s_q.t),
        .hit (hit_now)
    );

    gcal_alarm_match u_hit_adv (
        .cfg (s_q.al),
        .t   (t_adv),
        .hit (hit_adv)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rdy = !tick;
        acc_wr  = wr_en && s_q.open && (wr_addr != A_KEY);
        time_wr = acc_wr && (wr_addr >= A_SEC) && (wr_addr <= A_YEAR);

        if (tick && !time_wr) begin
            s_d.t = t_adv;
            if (hit_adv && !hit_now) s_d.flag = 1'b1;
        end

        if (wr_en && (wr_addr == A_KEY)) begin
            s_d.open = (wr_data[7:0] == KEY_VAL);
        end else if (acc_wr) begin
            case (wr_addr)
                A_SEC:  s_d.t.sec  = wr_data[5:0];
                A_MIN:  s_d.t.min  = wr_data[5:0];
                A_HOUR: s_d.t.hour = wr_data[4:0];
                A_DOW:  s_d.t.dow  = wr_data[2:0];
                A_DOM:  s_d.t.dom  = wr_data[4:0];
                A_MON:  s_d.t.mon  = wr_data[3:0];
                A_YEAR: s_d.t.year = wr_data[YEAR_W-1:0];
                A_AMIN: begin
                    s_d.al.min    = wr_data[5:0];
                    s_d.al.min_en = wr_data[EN_BIT];
                end
                A_AHR: begin
                    s_d.al.hour    = wr_data[4:0];
                    s_d.al.hour_en = wr_data[EN_BIT];
                end
                A_ADOW: begin
                    s_d.al.dow    = wr_data[2:0];
                    s_d.al.dow_en = wr_data[EN_BIT];
                end
                A_ADOM: begin
                    s_d.al.dom    = wr_data[4:0];
                    s_d.al.dom_en = wr_data[EN_BIT];
                end
                A_CTRL: if (wr_data[0]) s_d.flag = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= S_RST;
        else        s_q <= s_d;
    end

    assign sec        = s_q.t.sec;
    assign min        = s_q.t.min;
    assign hour       = s_q.t.hour;
    assign dow        = s_q.t.dow;
    assign dom        = s_q.t.dom;
    assign mon        = s_q.t.mon;
    assign year       = s_q.t.year;
    assign unlocked   = s_q.open;
    assign ready      = s_q.rdy;
    assign alarm_flag = s_q.flag;
endmodule

// File: rtl/gcal_checker.sv
module gcal_checker
    import gcal_pkg::*;
#(
    parameter logic [7:0] KEY_VAL = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [5:0]        sec,
    input logic [5:0]        min,
    input logic [4:0]        hour,
    input logic              unlocked,
    input logic              ready,
    input logic              alarm_flag
);
    logic unused_chk;
    assign unused_chk = ^wr_data[DATA_W-1:8];

    a_r4_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec < 6'd59) |=> (sec == $past(sec) + 6'd1));

    a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec == 6'd59) |=> (sec == 6'd0));

    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !tick) |=> ($stable(sec) && $stable(min) && $stable(hour)));

    a_r3_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KEY && wr_data[7:0] != KEY_VAL) |=> !unlocked);

    a_r3_good_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KEY && wr_data[7:0] == KEY_VAL) |=> unlocked);

    a_r10_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !ready);

    a_r10_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ready);

    a_r8_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick));
endmodule

bind guarded_calendar gcal_checker #(.KEY_VAL(KEY_VAL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sec        (sec),
    .min        (min),
    .hour       (hour),
    .unlocked   (unlocked),
    .ready      (ready),
    .alarm_flag (alarm_flag)
);

// File: tb/guarded_calendar_bench.sv
module guarded_calendar_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KEY = 8'hA5;
    localparam logic [15:0] EN = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  sec, min;
    logic [4:0]  hour, dom;
    logic [2:0]  dow;
    logic [3:0]  mon;
    logic [11:0] year;
    logic        unlocked, ready, alarm_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    guarded_calendar u_guarded_calendar (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sec(sec), .min(min),
        .hour(hour), .dow(dow), .dom(dom), .mon(mon), .year(year),
        .unlocked(unlocked), .ready(ready), .alarm_flag(alarm_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_time(input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s);
        wr(4'd7, 16'(y)); wr(4'd6, 16'(mo)); wr(4'd5, 16'(d));
        wr(4'd4, 16'(w)); wr(4'd3, 16'(h)); wr(4'd2, 16'(mi)); wr(4'd1, 16'(s));
    endtask

    task automatic day_roll(input string req, input int y, input int mo, input int d,
                            input int ey, input int emo, input int ed);
        set_time(y, mo, d, 2, 23, 59, 59);
        pulse();
        chk({req, " day"}, dom, ed);
        chk({req, " month"}, mon, emo);
        chk({req, " year"}, year, ey);
    endtask

    task automatic t_reset();
        chk("R1 sec", sec, 0);   chk("R1 min", min, 0);  chk("R1 hour", hour, 0);
        chk("R1 dow", dow, 0);   chk("R1 dom", dom, 1);  chk("R1 mon", mon, 1);
        chk("R1 year", year, 2000); chk("R1 locked", unlocked, 0);
        chk("R1 ready", ready, 1);  chk("R1 flag", alarm_flag, 0);
    endtask

    task automatic t_guard();
        wr(4'd1, 16'd30);
        chk("R2 locked sec write dropped", sec, 0);
        wr(4'd7, 16'd1999);
        chk("R2 locked year write dropped", year, 2000);
        wr(4'd0, 16'(KEY));
        chk("R3 unlock", unlocked, 1);
        wr(4'd1, 16'd30);
        chk("R2 unlocked write taken", sec, 30);
        wr(4'd0, 16'h005A);
        chk("R3 wrong key relocks", unlocked, 0);
        wr(4'd1, 16'd45);
        chk("R2 relocked write dropped", sec, 30);
        wr(4'd0, 16'(KEY));
        chk("R3 unlock again", unlocked, 1);
    endtask

    task automatic t_count();
        set_time(2023, 6, 15, 6, 23, 59, 58);
        pulse();
        chk("R4 sec step", sec, 59);
        chk("R4 min held", min, 59);
        pulse();
        chk("R4 sec wrap", sec, 0);   chk("R4 min wrap", min, 0);
        chk("R4 hour wrap", hour, 0); chk("R4 dow wrap", dow, 0);
        chk("R5 dom step", dom, 16);
        set_time(2023, 6, 15, 2, 9, 59, 59);
        pulse();
        chk("R4 hour carry", hour, 10);
        chk("R4 dom kept", dom, 15);
    endtask

    task automatic t_months();
        day_roll("R5 Apr30", 2023, 4, 30, 2023, 5, 1);
        day_roll("R5 Sep30", 2023, 9, 30, 2023, 10, 1);
        day_roll("R5 Jan31", 2023, 1, 31, 2023, 2, 1);
        day_roll("R5 Jan30", 2023, 1, 30, 2023, 1, 31);
        day_roll("R5 Feb28 common", 2023, 2, 28, 2023, 3, 1);
    endtask

    task automatic t_leap();
        day_roll("R6 Feb28 2024", 2024, 2, 28, 2024, 2, 29);
        day_roll("R6 Feb29 2024", 2024, 2, 29, 2024, 3, 1);
        day_roll("R6 Feb28 2100", 2100, 2, 28, 2100, 3, 1);
        day_roll("R6 Feb28 2000", 2000, 2, 28, 2000, 2, 29);
    endtask

    task automatic t_year();
        day_roll("R7 Dec31", 2023, 12, 31, 2024, 1, 1);
        day_roll("R7 year wrap", 4095, 12, 31, 0, 1, 1);
    endtask

    task automatic t_ready();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R10 ready low after tick", ready, 0);
        @(negedge clk);
        chk("R10 ready back high", ready, 1);
    endtask

    task automatic t_alarm();
        set_time(2023, 6, 15, 3, 7, 29, 59);
        wr(4'd8, EN | 16'd30);
        wr(4'd9, EN | 16'd7);
        chk("R8 no flag before tick", alarm_flag, 0);
        pulse();
        chk("R8 flag on match", alarm_flag, 1);
        pulse();
        chk("R9 flag sticky", alarm_flag, 1);
        wr(4'd12, 16'd1);
        chk("R9 flag cleared", alarm_flag, 0);
        pulse();
        chk("R9 no refire while match persists", alarm_flag, 0);
        wr(4'd8, EN | 16'd31);
        wr(4'd9, 16'd0);
        wr(4'd10, EN | 16'd5);
        wr(4'd1, 16'd59);
        pulse();
        chk("R8 minute hit but day of week mismatch", alarm_flag, 0);
        wr(4'd8, 16'd32);
        wr(4'd10, 16'd0);
        wr(4'd1, 16'd59);
        pulse();
        chk("R8 no field enabled", alarm_flag, 0);
        chk("R8 time advanced", min, 32);
    endtask

    task automatic t_collide();
        set_time(2023, 6, 15, 3, 8, 20, 10);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'd40;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R11 write wins", sec, 40);
        chk("R11 minute untouched", min, 20);
        pulse();
        chk("R11 normal tick after", sec, 41);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_guard();
        t_count();
        t_months();
        t_leap();
        t_year();
        t_ready();
        t_alarm();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule